// File: doc/BRIEF.md
# Byte Multiplier with Signed Correction

This unit multiplies two 8-bit operands and leaves the 16-bit result in a pair of product registers. The high register holds result bits 15:8 and the low register holds bits 7:0. Its core is an unsigned array multiplier. In unsigned mode the whole product is written on the clock edge that accepts the request.

Signed results come from the same unsigned product. The unit does not use a signed multiplier. After the unsigned product is written, up to two correction steps run in a fixed order, and each one subtracts an operand from the high product byte modulo 256. The first step runs when the second operand is negative and subtracts the first operand. The second step runs when the first operand is negative and subtracts the second operand. A step whose sign bit is clear is skipped. The low byte is never touched by a correction.

A caller raises a request together with the two operands and a mode bit. It then waits for a one-cycle done pulse. Requests that arrive while the unit is busy are dropped. The unit holds no condition flags of any kind.

Top module: `bytemul_unit`

## Requirements
- R1: In unsigned mode (`signed_i`=0), the cycle after an accepted request shows `done_o`=1, `prod_hi_o` = bits 15:8 and `prod_lo_o` = bits 7:0 of the unsigned product `opw_i*opf_i`.
- R2: In signed mode (`signed_i`=1), when `done_o` rises, `{prod_hi_o,prod_lo_o}` equals the 16-bit two's-complement product of the two operands, each read as a signed byte.
- R3: In signed mode, `done_o` rises N cycles after acceptance, with N = 1 + `opf_i[7]` + `opw_i[7]`. A step whose sign bit is 0 is skipped.
- R4: Corrections run in a fixed order: the step for `opf_i[7]` (high byte minus `opw_i`) comes first, then the step for `opw_i[7]` (high byte minus `opf_i`). Each step wraps modulo 256.
- R5: A correction step changes only `prod_hi_o`; `prod_lo_o` keeps the value written by the multiply.
- R6: `busy_o` is 1 in every cycle from the one after an accepted signed request that needs a correction, up to but not including the cycle in which `done_o` is 1. `busy_o` and `done_o` are never 1 together.
- R7: `done_o` is 1 for exactly one cycle per accepted request. A request is accepted when `req_i`=1 and `busy_o`=0 at a rising clock edge.
- R8: A request made while `busy_o`=1 has no effect. Operand and mode inputs that change after acceptance do not alter the result or the cycle count.
- R9: While `rst_n`=0, `prod_hi_o`, `prod_lo_o`, `busy_o` and `done_o` are all 0.
- R10: With no accepted request and no correction under way, both product bytes hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Multiply request |
| signed_i | input | 1 | 1 = signed mode, 0 = unsigned mode |
| opw_i | input | 8 | First (working) operand |
| opf_i | input | 8 | Second operand |
| busy_o | output | 1 | Correction sequence in progress |
| done_o | output | 1 | One-cycle pulse: product is final |
| prod_hi_o | output | 8 | Product bits 15:8 |
| prod_lo_o | output | 8 | Product bits 7:0 |

## Verification
The bench aims at the four sign combinations: 0x80 by 0x80, 0xFF by 0xFF, 0x80 by 0x7F, and zero against a negative operand. A design that runs the corrections in the wrong order, uses the wrong operand, or lets a subtraction reach into the low byte gives a wrong signed product. It also checks that each sign combination takes the right number of cycles, so a unit that never skips a step, or always skips one, is caught by the latency check. While the unit is busy the bench keeps raising requests with scrambled operands. A unit that accepts them, or that reads its live inputs instead of the latched operands, shows a corrupted result.

// File: rtl/bm_pkg.sv
package bm_pkg;

  // Sequencer states: idle/multiply, correction for second-operand sign,
  // correction for first-operand sign.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIX_F = 2'd1,
    ST_FIX_W = 2'd2
  } bm_state_e;

  // Which latched operand a correction subtracts from the high byte.
  typedef enum logic {
    SUB_OPW = 1'b0,
    SUB_OPF = 1'b1
  } bm_subsel_e;

endpackage

// File: rtl/bm_array_mult.sv
module bm_array_mult #(
  parameter int W = 8
) (
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);

  localparam int W2 = 2 * W;

  // Running sums of the shifted partial products, one row per multiplier bit.
  logic [W2-1:0] acc [0:W];

  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [W-1:0]  gated;
    logic [W2-1:0] shifted;
    assign gated     = mcand_i & {W{mplier_i[i]}};
    assign shifted   = W2'(gated) << i;
    assign acc[i+1]  = acc[i] + shifted;
  end

  assign prod_o = acc[W];

endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       signed_i,
  input  logic       w_msb_i,
  input  logic       f_msb_i,
  output logic       load_o,
  output logic       sub_en_o,
  output bm_subsel_e sub_sel_o,
  output logic       busy_o,
  output logic       done_o
);

  bm_state_e state_q, state_d;
  logic      pend_w_q, pend_w_d;
  logic      done_q, done_d;
  logic      accept;

  assign accept = req_i && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    pend_w_d = pend_w_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          pend_w_d = signed_i & w_msb_i;
          if (signed_i && f_msb_i) begin
            state_d = ST_FIX_F;
          end else if (signed_i && w_msb_i) begin
            state_d = ST_FIX_W;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_FIX_F: begin
        if (pend_w_q) begin
          state_d = ST_FIX_W;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_FIX_W: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_w_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_w_q <= pend_w_d;
      done_q   <= done_d;
    end
  end

  assign load_o    = accept;
  assign sub_en_o  = (state_q != ST_IDLE);
  assign sub_sel_o = (state_q == ST_FIX_W) ? SUB_OPF : SUB_OPW;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

  // R4
  fixw_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIX_W) |=> (state_q == ST_IDLE && done_q));

  // R4
  fixf_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIX_W) |-> $past(state_q == ST_FIX_F || accept));

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en_o && req_i) |-> !load_o);

endmodule

// File: rtl/bm_datapath.sv
module bm_datapath
  import bm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         sub_en_i,
  input  bm_subsel_e   sub_sel_i,
  input  logic [W-1:0] opw_i,
  input  logic [W-1:0] opf_i,
  input  logic [2*W-1:0] prod_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  logic [W-1:0] opw_q, opf_q;
  logic [W-1:0] hi_q, hi_d;
  logic [W-1:0] lo_q, lo_d;
  logic [W-1:0] sub_operand;
  logic         hi_en, lo_en, op_en;

  assign sub_operand = (sub_sel_i == SUB_OPF) ? opf_q : opw_q;

  // Clock enables
  assign op_en = load_i;
  assign lo_en = load_i;
  assign hi_en = load_i | sub_en_i;

  always_comb begin
    lo_d = prod_i[W-1:0];
    if (load_i) begin
      hi_d = prod_i[2*W-1:W];
    end else begin
      hi_d = hi_q - sub_operand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opw_q <= '0;
      opf_q <= '0;
    end else if (op_en) begin
      opw_q <= opw_i;
      opf_q <= opf_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R5
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en_i && !load_i) |=> $stable(lo_q));

  // R10
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !sub_en_i) |=> ($stable(hi_q) && $stable(lo_q)));

  // R4
  sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en_i && !load_i && sub_sel_i == SUB_OPW) |=> (hi_q == $past(hi_q - opw_q)));

endmodule

// File: rtl/bytemul_unit.sv
module bytemul_unit
  import bm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic         signed_i,
  input  logic [W-1:0] opw_i,
  input  logic [W-1:0] opf_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o
);

  localparam int W2 = 2 * W;

  logic [W2-1:0] raw_prod;
  logic          load, sub_en;
  bm_subsel_e    sub_sel;

  bm_array_mult #(.W(W)) i_mult (
    .mcand_i (opw_i),
    .mplier_i(opf_i),
    .prod_o  (raw_prod)
  );

  bm_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .signed_i (signed_i),
    .w_msb_i  (opw_i[W-1]),
    .f_msb_i  (opf_i[W-1]),
    .load_o   (load),
    .sub_en_o (sub_en),
    .sub_sel_o(sub_sel),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  bm_datapath #(.W(W)) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .sub_en_i (sub_en),
    .sub_sel_i(sub_sel),
    .opw_i    (opw_i),
    .opf_i    (opf_i),
    .prod_i   (raw_prod),
    .hi_o     (prod_hi_o),
    .lo_o     (prod_lo_o)
  );

  // R1
  unsigned_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o && !signed_i) |=>
      (done_o && {prod_hi_o, prod_lo_o} == $past(W2'(opw_i) * W2'(opf_i))));

  // R3
  signed_pos_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o && signed_i && !opw_i[W-1] && !opf_i[W-1]) |=> done_o);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

endmodule

// File: tb/test_bytemul_unit.sv
module test_bytemul_unit;

  logic       clk;
  logic       rst_n;
  logic       req_i;
  logic       signed_i;
  logic [7:0] opw_i;
  logic [7:0] opf_i;
  logic       busy_o;
  logic       done_o;
  logic [7:0] prod_hi_o;
  logic [7:0] prod_lo_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 0;

  bytemul_unit i_bytemul_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .signed_i (signed_i),
    .opw_i    (opw_i),
    .opf_i    (opf_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .prod_hi_o(prod_hi_o),
    .prod_lo_o(prod_lo_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      failures = failures + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b,
                                           input bit sgn);
    if (sgn) return 16'($signed(a) * $signed(b));
    return 16'({8'd0, a} * {8'd0, b});
  endfunction

  function automatic int ref_lat(input logic [7:0] a, input logic [7:0] b, input bit sgn);
    if (!sgn) return 1;
    return 1 + int'(b[7]) + int'(a[7]);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input bit sgn,
                        input bit poke);
    logic [15:0] exp_p;
    logic [15:0] got;
    int          lat;
    int          n;
    string       rq;
    exp_p = ref_prod(a, b, sgn);
    lat   = ref_lat(a, b, sgn);
    rq    = sgn ? "R2" : "R1";
    @(negedge clk);
    opw_i = a; opf_i = b; signed_i = sgn; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    n = 1;
    while (!done_o && n < 8) begin
      // R6: busy between acceptance and done
      check(busy_o == 1'b1, "R6 busy", 32'(busy_o), 32'd1);
      if (poke) begin
        // R8: requests during busy with scrambled inputs
        req_i = 1'b1; opw_i = 8'($urandom); opf_i = 8'($urandom);
        signed_i = 1'($urandom);
      end
      @(negedge clk);
      req_i = 1'b0;
      n = n + 1;
    end
    got = {prod_hi_o, prod_lo_o};
    check(done_o == 1'b1, "R7 done", 32'(done_o), 32'd1);
    check(busy_o == 1'b0, "R6 busy at done", 32'(busy_o), 32'd0);
    // R3 latency
    check(n == lat, sgn ? "R3 latency" : "R1 latency", 32'(n), 32'(lat));
    check(got == exp_p, poke ? "R8 result" : rq, 32'(got), 32'(exp_p));
    @(negedge clk);
    // R7 single pulse, R10 hold
    check(done_o == 1'b0, "R7 pulse", 32'(done_o), 32'd0);
    check({prod_hi_o, prod_lo_o} == got, "R10 hold", 32'({prod_hi_o, prod_lo_o}),
          32'(got));
  endtask

  task automatic check_reset_state(input string tag);
    check({busy_o, done_o, prod_hi_o, prod_lo_o} == 18'd0, tag,
          32'({busy_o, done_o, prod_hi_o, prod_lo_o}), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_i = 1'b0; signed_i = 1'b0; opw_i = '0; opf_i = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R9
    check_reset_state("R9 initial reset");
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners: R1 unsigned extremes
    run_op(8'hFF, 8'hFF, 1'b0, 1'b0);
    run_op(8'h00, 8'hA5, 1'b0, 1'b0);
    run_op(8'h80, 8'h80, 1'b0, 1'b0);
    // R2/R3/R4 signed sign combinations
    run_op(8'h80, 8'h80, 1'b1, 1'b0);
    run_op(8'hFF, 8'hFF, 1'b1, 1'b0);
    run_op(8'h80, 8'h7F, 1'b1, 1'b0);
    run_op(8'h7F, 8'h80, 1'b1, 1'b0);
    run_op(8'h00, 8'h81, 1'b1, 1'b0);
    run_op(8'h12, 8'h34, 1'b1, 1'b0);
    // R8 busy requests ignored
    run_op(8'h80, 8'h80, 1'b1, 1'b1);
    run_op(8'hC3, 8'h05, 1'b1, 1'b1);

    // R10: idle with no request keeps product
    begin
      logic [15:0] held;
      held = {prod_hi_o, prod_lo_o};
      repeat (5) @(negedge clk);
      check({prod_hi_o, prod_lo_o} == held, "R10 idle hold",
            32'({prod_hi_o, prod_lo_o}), 32'(held));
    end

    // Random mix in both modes
    for (int i = 0; i < 3000; i++) begin
      run_op(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    end

    // R9: reset in the middle of a signed sequence
    @(negedge clk);
    opw_i = 8'h90; opf_i = 8'h91; signed_i = 1'b1; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check_reset_state("R9 mid-op reset");
    @(negedge clk);
    check_reset_state("R9 held reset");
    rst_n = 1'b1;
    @(negedge clk);
    run_op(8'h90, 8'h91, 1'b1, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule